// File: doc/BRIEF.md
# PLL Control Register Bank

This block keeps the configuration of a single phase-locked loop in a small set of 32-bit control words. A bus master writes a word together with a per-bit write enable carried in the upper sixteen bits of the same word. Only those lower bits whose enable bit is set take the new value, so software can change one field without first reading the word back. The stored fields go straight to an external PLL model. These fields are the three divider settings held as value-minus-one, a bandwidth trim code, and the reset, power-down and bypass controls.

A fifth word holds a two-bit route code. It picks where the downstream clock comes from: the reference clock, the PLL output, or a slow low-frequency clock. The code is decoded into a one-hot select vector. A combinational read port returns the stored lower half of any mapped word. A helper output computes the resulting output frequency from a parent frequency input and the stored fields, and it takes the bypass control into account.

Top module: `pll_ctrl_bank`

## Requirements
- R1: The word at byte offset 0 holds the output divider minus one in bits 3:0 and the reference divider minus one in bits 13:8. These appear on `out_div_m1` and `ref_div_m1`.
- R2: The word at byte offset 4 holds the feedback multiplier minus one in bits 12:0, shown on `fb_mul_m1`. The word at offset 8 holds a bandwidth trim code in bits 11:0, shown on `bw_trim`.
- R3: The word at byte offset 12 holds bypass in bit 0, power-down in bit 1 and PLL reset in bit 5. `pll_enabled` is 1 exactly when power-down is 0.
- R4: The word at byte offset 16 holds the route code in bits 1:0. `src_sel` is one-hot: bit 0 for code 0 (reference), bit 1 for code 1 (PLL output), bit 2 for code 2 (low-frequency clock). It is all zero for code 3.
- R5: On a write, stored bit i of the addressed word takes `wr_data[i]` only when `wr_data[i+16]` is 1. All other bits keep their value. The new value is visible from the clock edge that accepts the write.
- R6: `rd_data` returns the stored bits of the word at `rd_addr` in their field positions, without any clock delay. Unassigned bits read as 0, and bits 31:16 always read as 0.
- R7: A write to any offset other than 0, 4, 8, 12 or 16 changes nothing, and this includes unaligned offsets. A read of such an offset returns 0.
- R8: After reset, power-down is 1, bypass and PLL reset are 0, the route code is 0, and every divider and trim field is 0.
- R9: With bypass clear, `out_freq` = floor(floor(parent × (FB+1) / (REF+1)) / (OUT+1)). FB, REF and OUT are the stored minus-one fields.
- R10: With bypass set, `out_freq` equals `parent_freq` whatever the divider fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Upper half: bit enables; lower half: data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Stored lower half of the addressed word |
| parent_freq | input | FREQ_W | Parent clock frequency |
| out_div_m1 | output | 4 | Output divider minus one |
| ref_div_m1 | output | 6 | Reference divider minus one |
| fb_mul_m1 | output | 13 | Feedback multiplier minus one |
| bw_trim | output | 12 | Bandwidth trim code |
| pll_byp | output | 1 | Bypass control |
| pll_pd | output | 1 | Power-down control |
| pll_rst | output | 1 | PLL reset control |
| pll_enabled | output | 1 | PLL enabled (power-down clear) |
| src_mode | output | 2 | Stored route code |
| src_sel | output | 3 | One-hot clock source select |
| out_freq | output | FREQ_W+13 | Effective output frequency |

## Verification
A bit that is wrongly held or wrongly written shows up on two outputs in the cycle after the write edge. One is its field output. The other is `rd_data`, which reads the word combinationally. A fault in the mask or the address decode gives the wrong field value at once. A fault in the route decode or the rate arithmetic shows on `src_sel` or `out_freq` in the same cycle as the stored state that drives it. The bench compares every output against its model after each clock edge. A corruption is therefore reported within one cycle of the edge that caused it.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

    localparam int OUT_W  = 4;
    localparam int REF_W  = 6;
    localparam int FB_W   = 13;
    localparam int BW_W   = 12;
    localparam int MODE_W = 2;
    localparam int NSRC   = 3;
    localparam int NWORDS = 5;

    // Bit positions inside the lower halves
    localparam int OUT_LSB  = 0;
    localparam int REF_LSB  = 8;
    localparam int FB_LSB   = 0;
    localparam int BW_LSB   = 0;
    localparam int BYP_BIT  = 0;
    localparam int PD_BIT   = 1;
    localparam int RST_BIT  = 5;
    localparam int MODE_LSB = 0;

    // Word indices (byte offset / 4)
    localparam int W_DIV  = 0;
    localparam int W_FB   = 1;
    localparam int W_BW   = 2;
    localparam int W_CTL  = 3;
    localparam int W_ROUTE = 4;

    typedef enum logic [MODE_W-1:0] {
        SRC_REF  = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SLOW = 2'd2,
        SRC_NONE = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic [OUT_W-1:0] out_div;
        logic [REF_W-1:0] ref_div;
        logic [FB_W-1:0]  fb_mul;
        logic [BW_W-1:0]  bw;
        logic             byp;
        logic             pd;
        logic             prst;
        src_mode_e        mode;
    } pll_cfg_t;

    // Lower-half image of a stored word
    function automatic logic [15:0] word_image(input pll_cfg_t c, input int idx);
        logic [15:0] w;
        w = '0;
        case (idx)
            W_DIV: begin
                w[OUT_LSB +: OUT_W] = c.out_div;
                w[REF_LSB +: REF_W] = c.ref_div;
            end
            W_FB:  w[FB_LSB +: FB_W] = c.fb_mul;
            W_BW:  w[BW_LSB +: BW_W] = c.bw;
            W_CTL: begin
                w[BYP_BIT] = c.byp;
                w[PD_BIT]  = c.pd;
                w[RST_BIT] = c.prst;
            end
            W_ROUTE: w[MODE_LSB +: MODE_W] = c.mode;
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pllreg_field.sv
module pllreg_field #(
    parameter int          W   = 4,
    parameter int          LSB = 0,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic [31:0]  wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] en_bits;
    logic [W-1:0] new_bits;

    assign en_bits  = wdata[16+LSB +: W];
    assign new_bits = wdata[LSB +: W];

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST;
        else if (hit)
            q <= (q & ~en_bits) | (new_bits & en_bits);
    end
endmodule

// File: rtl/pllreg_srcsel.sv
module pllreg_srcsel
    import pllreg_pkg::*;
(
    input  src_mode_e       mode,
    output logic [NSRC-1:0] sel
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign sel[i] = (mode == src_mode_e'(i));
    end
endmodule

// File: rtl/pllreg_rate.sv
module pllreg_rate
    import pllreg_pkg::*;
#(
    parameter int FREQ_W = 32,
    localparam int RATE_W = FREQ_W + FB_W
) (
    input  logic [FREQ_W-1:0] parent,
    input  pll_cfg_t          cfg,
    output logic [RATE_W-1:0] rate
);
    logic [FB_W:0]     fb_n;
    logic [REF_W:0]    ref_n;
    logic [OUT_W:0]    out_n;
    logic [RATE_W-1:0] prod;
    logic [RATE_W-1:0] q_ref;
    logic [RATE_W-1:0] q_out;

    assign fb_n  = {1'b0, cfg.fb_mul}  + (FB_W+1)'(1);
    assign ref_n = {1'b0, cfg.ref_div} + (REF_W+1)'(1);
    assign out_n = {1'b0, cfg.out_div} + (OUT_W+1)'(1);

    assign prod  = RATE_W'(parent) * RATE_W'(fb_n);
    assign q_ref = prod  / RATE_W'(ref_n);
    assign q_out = q_ref / RATE_W'(out_n);

    assign rate = cfg.byp ? RATE_W'(parent) : q_out;
endmodule

// File: rtl/pll_ctrl_bank.sv
module pll_ctrl_bank
    import pllreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int FREQ_W = 32,
    localparam int RATE_W = FREQ_W + FB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [FREQ_W-1:0] parent_freq,
    output logic [OUT_W-1:0]  out_div_m1,
    output logic [REF_W-1:0]  ref_div_m1,
    output logic [FB_W-1:0]   fb_mul_m1,
    output logic [BW_W-1:0]   bw_trim,
    output logic              pll_byp,
    output logic              pll_pd,
    output logic              pll_rst,
    output logic              pll_enabled,
    output logic [MODE_W-1:0] src_mode,
    output logic [NSRC-1:0]   src_sel,
    output logic [RATE_W-1:0] out_freq
);
    pll_cfg_t          cfg;
    logic [NWORDS-1:0] wr_hit;
    logic [MODE_W-1:0] mode_q;

    // Write decode: aligned offsets of mapped words only
    for (genvar k = 0; k < NWORDS; k++) begin : g_dec
        assign wr_hit[k] = wr_en && (wr_addr[1:0] == 2'b00)
                           && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(k));
    end

    pllreg_field #(.W(OUT_W), .LSB(OUT_LSB)) u_out (
        .clk(clk), .rst(rst), .hit(wr_hit[W_DIV]), .wdata(wr_data), .q(cfg.out_div));
    pllreg_field #(.W(REF_W), .LSB(REF_LSB)) u_ref (
        .clk(clk), .rst(rst), .hit(wr_hit[W_DIV]), .wdata(wr_data), .q(cfg.ref_div));
    pllreg_field #(.W(FB_W), .LSB(FB_LSB)) u_fb (
        .clk(clk), .rst(rst), .hit(wr_hit[W_FB]), .wdata(wr_data), .q(cfg.fb_mul));
    pllreg_field #(.W(BW_W), .LSB(BW_LSB)) u_bw (
        .clk(clk), .rst(rst), .hit(wr_hit[W_BW]), .wdata(wr_data), .q(cfg.bw));
    pllreg_field #(.W(1), .LSB(BYP_BIT), .RST(1'b0)) u_byp (
        .clk(clk), .rst(rst), .hit(wr_hit[W_CTL]), .wdata(wr_data), .q(cfg.byp));
    pllreg_field #(.W(1), .LSB(PD_BIT), .RST(1'b1)) u_pd (
        .clk(clk), .rst(rst), .hit(wr_hit[W_CTL]), .wdata(wr_data), .q(cfg.pd));
    pllreg_field #(.W(1), .LSB(RST_BIT), .RST(1'b0)) u_prst (
        .clk(clk), .rst(rst), .hit(wr_hit[W_CTL]), .wdata(wr_data), .q(cfg.prst));
    pllreg_field #(.W(MODE_W), .LSB(MODE_LSB), .RST(SRC_REF)) u_mode (
        .clk(clk), .rst(rst), .hit(wr_hit[W_ROUTE]), .wdata(wr_data), .q(mode_q));

    assign cfg.mode = src_mode_e'(mode_q);

    // Combinational read port
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if ((rd_addr[1:0] == 2'b00) && (rd_addr[ADDR_W-1:2] == (ADDR_W-2)'(k)))
                rd_data = {16'h0000, word_image(cfg, k)};
        end
    end

    pllreg_srcsel u_sel (
        .mode(cfg.mode),
        .sel (src_sel)
    );

    pllreg_rate #(.FREQ_W(FREQ_W)) u_rate (
        .parent(parent_freq),
        .cfg   (cfg),
        .rate  (out_freq)
    );

    assign out_div_m1  = cfg.out_div;
    assign ref_div_m1  = cfg.ref_div;
    assign fb_mul_m1   = cfg.fb_mul;
    assign bw_trim     = cfg.bw;
    assign pll_byp     = cfg.byp;
    assign pll_pd      = cfg.pd;
    assign pll_rst     = cfg.prst;
    assign pll_enabled = ~cfg.pd;
    assign src_mode    = mode_q;
endmodule

// File: rtl/pll_ctrl_bank_chk.sv
module pll_ctrl_bank_chk #(
    parameter int ADDR_W = 8,
    parameter int FREQ_W = 32,
    localparam int RATE_W = FREQ_W + 13
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [31:0]       rd_data,
    input logic [FREQ_W-1:0] parent_freq,
    input logic [3:0]        out_div_m1,
    input logic [5:0]        ref_div_m1,
    input logic [12:0]       fb_mul_m1,
    input logic [11:0]       bw_trim,
    input logic              pll_byp,
    input logic              pll_pd,
    input logic              pll_rst,
    input logic [1:0]        src_mode,
    input logic [2:0]        src_sel,
    input logic [RATE_W-1:0] out_freq
);
    logic [42:0] state_v;
    logic        wr_unmapped;

    assign state_v = {out_div_m1, ref_div_m1, fb_mul_m1, bw_trim,
                      pll_byp, pll_pd, pll_rst, src_mode, 4'b0000};
    assign wr_unmapped = (wr_addr[1:0] != 2'b00) || (wr_addr[ADDR_W-1:2] > (ADDR_W-2)'(4));

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (pll_pd && !pll_byp && !pll_rst && src_mode == 2'd0 &&
                 out_div_m1 == '0 && ref_div_m1 == '0 && fb_mul_m1 == '0 && bw_trim == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(state_v)); // R5

    AST_ZERO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[31:16] == 16'h0000) |=> $stable(state_v)); // R5

    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_unmapped) |=> $stable(state_v)); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:16] == 16'h0000); // R6

    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (src_mode != 2'd3) |-> ($countones(src_sel) == 1)); // R4

    AST_SRC_NONE: assert property (@(posedge clk) disable iff (rst)
        (src_mode == 2'd3) |-> (src_sel == 3'b000)); // R4

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        pll_byp |-> (out_freq == RATE_W'(parent_freq))); // R10
endmodule

bind pll_ctrl_bank pll_ctrl_bank_chk #(.ADDR_W(ADDR_W), .FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .parent_freq(parent_freq), .out_div_m1(out_div_m1),
    .ref_div_m1(ref_div_m1), .fb_mul_m1(fb_mul_m1), .bw_trim(bw_trim),
    .pll_byp(pll_byp), .pll_pd(pll_pd), .pll_rst(pll_rst),
    .src_mode(src_mode), .src_sel(src_sel), .out_freq(out_freq));

// File: tb/pll_ctrl_bank_bench.sv
module pll_ctrl_bank_bench;
    localparam int ADDR_W = 8;
    localparam int FREQ_W = 32;
    localparam int RATE_W = FREQ_W + 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [FREQ_W-1:0] parent_freq = 32'd24000;
    logic [3:0]  out_div_m1;
    logic [5:0]  ref_div_m1;
    logic [12:0] fb_mul_m1;
    logic [11:0] bw_trim;
    logic pll_byp, pll_pd, pll_rst, pll_enabled;
    logic [1:0] src_mode;
    logic [2:0] src_sel;
    logic [RATE_W-1:0] out_freq;

    int checks = 0;
    int errors = 0;

    // Behavioural model: lower halves of five words
    logic [15:0] mw [5];
    logic [15:0] valid_m [5];

    always #2.5 clk = ~clk;

    pll_ctrl_bank #(.ADDR_W(ADDR_W), .FREQ_W(FREQ_W)) u_pll_ctrl_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .parent_freq(parent_freq),
        .out_div_m1(out_div_m1), .ref_div_m1(ref_div_m1), .fb_mul_m1(fb_mul_m1),
        .bw_trim(bw_trim), .pll_byp(pll_byp), .pll_pd(pll_pd), .pll_rst(pll_rst),
        .pll_enabled(pll_enabled), .src_mode(src_mode), .src_sel(src_sel),
        .out_freq(out_freq));

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [ADDR_W-1:0] a);
        if (a[1:0] == 2'b00 && a[ADDR_W-1:2] < 5) return mw[a[ADDR_W-1:2]];
        return 16'h0000;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) mw[k] = 16'h0000;
        mw[3] = 16'h0002;
    endtask

    task automatic compare_all();
        longint unsigned nf, nr, no, p, expf;
        logic [2:0] esel;
        chk("R6", "rd_data", rd_data, {16'h0, model_read(rd_addr)});
        chk("R1", "out_div", out_div_m1, mw[0][3:0]);
        chk("R1", "ref_div", ref_div_m1, mw[0][13:8]);
        chk("R2", "fb_mul", fb_mul_m1, mw[1][12:0]);
        chk("R2", "bw_trim", bw_trim, mw[2][11:0]);
        chk("R3", "ctl", {pll_rst, pll_pd, pll_byp}, {mw[3][5], mw[3][1], mw[3][0]});
        chk("R3", "enabled", pll_enabled, !mw[3][1]);
        case (mw[4][1:0])
            2'd0: esel = 3'b001;
            2'd1: esel = 3'b010;
            2'd2: esel = 3'b100;
            default: esel = 3'b000;
        endcase
        chk("R4", "src_mode", src_mode, mw[4][1:0]);
        chk("R4", "src_sel", src_sel, esel);
        p  = parent_freq;
        nf = mw[1][12:0] + 1;
        nr = mw[0][13:8] + 1;
        no = mw[0][3:0] + 1;
        if (mw[3][0]) begin
            chk("R10", "out_freq bypass", out_freq, p);
        end else begin
            expf = ((p * nf) / nr) / no;
            chk("R9", "out_freq", out_freq, expf);
        end
    endtask

    // One clock: model follows the edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        #1;
        if (rst) model_reset();
        else if (wr_en && wr_addr[1:0] == 2'b00 && wr_addr[ADDR_W-1:2] < 5) begin
            int idx = int'(wr_addr[ADDR_W-1:2]);
            logic [15:0] m = wr_data[31:16] & valid_m[idx];
            mw[idx] = (mw[idx] & ~m) | (wr_data[15:0] & m);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        valid_m[0] = 16'h3F0F; valid_m[1] = 16'h1FFF; valid_m[2] = 16'h0FFF;
        valid_m[3] = 16'h0023; valid_m[4] = 16'h0003;
        model_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        // R8: reset state observed at ports
        rd_addr = 8'd12;
        @(negedge clk);
        chk("R8", "pd after reset", pll_pd, 1);
        chk("R8", "ctl word after reset", rd_data, 32'h0000_0002);
        chk("R8", "route after reset", src_sel, 3'b001);

        // Full-enable writes to each word
        wr(8'd0,  32'hFFFF_0503);          // R1: NR-1=5, NO-1=3
        wr(8'd4,  32'hFFFF_0063);          // R2: NF-1=99
        wr(8'd8,  32'hFFFF_0ABC);          // R2
        wr(8'd12, 32'hFFFF_0000);          // R3: power up
        chk("R3", "enabled after clear", pll_enabled, 1);
        wr(8'd16, 32'hFFFF_0001);          // R4: PLL output
        chk("R9", "rate 24000*100/6/4", out_freq, 45'd100000);

        // R5: partial enables
        wr(8'd0, 32'h000F_FFF7);            // only output divider bits
        chk("R5", "ref_div untouched", ref_div_m1, 6'd5);
        chk("R5", "out_div updated", out_div_m1, 4'd7);
        wr(8'd4, 32'h0000_1FFF);            // no enables
        chk("R5", "fb_mul held", fb_mul_m1, 13'd99);

        // R10: bypass
        wr(8'd12, 32'h0001_0001);
        chk("R10", "bypass rate", out_freq, 45'd24000);
        wr(8'd12, 32'h0023_0020);           // reset on, bypass off, pd off
        chk("R3", "pll_rst set", pll_rst, 1);

        // R7: unmapped and unaligned
        wr(8'd20, 32'hFFFF_FFFF);
        wr(8'd2,  32'hFFFF_FFFF);
        wr(8'd64, 32'hFFFF_FFFF);
        rd_addr = 8'd20;
        @(negedge clk);
        chk("R7", "unmapped read", rd_data, 32'h0);
        rd_addr = 8'd1;
        @(negedge clk);
        chk("R7", "unaligned read", rd_data, 32'h0);

        // R4: every route code
        for (int c = 0; c < 4; c++) wr(8'd16, 32'h0003_0000 | 32'(c));

        // Mixed random traffic
        for (int n = 0; n < 600; n++) begin
            wr_en = ($urandom % 4) != 0;
            wr_addr = ADDR_W'($urandom % 24);
            wr_data = $urandom;
            rd_addr = ADDR_W'($urandom % 24);
            if (n % 50 == 0) parent_freq = $urandom;
            step();
        end
        wr_en = 1'b0;

        // R8: reset mid-run restores defaults
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R8", "ref_div after re-reset", ref_div_m1, 0);
        chk("R8", "pd after re-reset", pll_pd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule